// File: doc/BRIEF.md
# External Bus Cycle Timing Sequencer

This block produces the control strobes for one chip-select region of a simple external memory bus. An internal master hands it a transfer request: direction, a burst flag and a beat count. It also receives a configuration word. The block then runs one bus cycle. It first drives a start/address-latch strobe and holds address-valid through a programmable setup time. It then asserts an active-low chip select and issues one internal acknowledge pulse per beat after a programmable number of wait states. It finishes with a programmable address hold before it returns to idle.

The configuration word is captured when a request is accepted, so it may change while a transfer is in progress without disturbing that transfer. In a burst, the first beat always uses the primary wait count. The beats after it may use a separate secondary count. Hold time is added only once, after the last beat. The read hold length also depends on an auto-acknowledge flag.

Top module: `bus_cycle_seq`

## Requirements
- R1: Configuration word layout: bits 5:0 primary wait count, 11:6 secondary wait count, 12 secondary enable, 13 strobe extend, 15:14 setup code, 17:16 read hold code, 19:18 write hold code, 20 auto-acknowledge. Bits 31:21 are reserved and have no effect on any output.
- R2: `ready` is high only when the sequencer is idle. A request is accepted on a rising edge where `req_valid` and `ready` are both high. From that edge onward, `addr_valid` is high, and it stays high until the hold phase ends.
- R3: With setup code S (0..3), `cs_n` goes low on the (S+1)-th rising edge after `addr_valid` rises.
- R4: With extend bit 0, `xfer_strobe` is high for exactly the first cycle of the transfer. With extend bit 1, it stays high until the first rising edge after `cs_n` goes low.
- R5: Each beat lasts W wait cycles with `cs_n` low and ends with a single-cycle `xfer_ack`. When secondary enable is 0, W is the primary count for every beat. The first beat always uses the primary count.
- R6: When secondary enable is 1, every burst beat after the first uses the secondary count as W.
- R7: A single transfer has one beat. A burst has `req_beats` beats, and a count of 0 is treated as 1. `cs_n` stays low without a gap across all beats and goes high on the edge after the last `xfer_ack`. No hold is added between beats.
- R8: After the last beat of a read, `addr_valid` stays high for n+1 cycles when auto-acknowledge is 1, or n cycles when it is 0, where n is the read hold code. `data_drive` stays low during reads.
- R9: After the last beat of a write, `addr_valid` and `data_drive` stay high for n+1 cycles, where n is the write hold code. `data_drive` is high from the cycle in which `cs_n` goes low until the end of that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst transfer |
| req_beats | input | BEAT_W | Beat count for a burst |
| cfg_word | input | CFG_W | Timing configuration, layout in R1 |
| ready | output | 1 | Idle, able to accept a request |
| xfer_strobe | output | 1 | Transfer-start / address-latch strobe |
| cs_n | output | 1 | Active-low chip select |
| addr_valid | output | 1 | Address and attributes driven |
| data_drive | output | 1 | Write data driven |
| xfer_ack | output | 1 | Internal per-beat acknowledge pulse |

## Verification
The assertions assume that requests are well formed. The request fields are stable in any cycle where `req_valid` is high. A request raised while the sequencer is busy is simply not taken. The bench raises `req_valid` for exactly one cycle, and only while `ready` is high, so every request is accepted at a known edge. It then lowers `req_valid` and keeps it low until the transfer finishes. The configuration word is changed only between transfers, which agrees with the capture-on-accept rule.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int WS_W   = 6,
  parameter int BEAT_W = 4,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              ready,
  output logic              xfer_strobe,
  output logic              cs_n,
  output logic              addr_valid,
  output logic              data_drive,
  output logic              xfer_ack
);
  localparam int PWS_LO = 0;
  localparam int SWS_LO = WS_W;
  localparam int SEN_B  = 2 * WS_W;
  localparam int EXT_B  = SEN_B + 1;
  localparam int SET_LO = SEN_B + 2;
  localparam int RDH_LO = SEN_B + 4;
  localparam int WRH_LO = SEN_B + 6;
  localparam int AA_B   = SEN_B + 8;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_BEAT, S_HOLD} phase_t;

  phase_t            state;
  logic [WS_W-1:0]   cnt;
  logic [BEAT_W-1:0] beats_left;
  logic [WS_W-1:0]   pri_q, sec_q;
  logic              sec_en_q, ext_q, wr_q, strb_q;
  logic [2:0]        hold_q;

  wire             accept   = req_valid && (state == S_IDLE);
  wire [WS_W-1:0]  c_pri    = cfg_word[PWS_LO +: WS_W];
  wire [WS_W-1:0]  c_sec    = cfg_word[SWS_LO +: WS_W];
  wire [1:0]       c_set    = cfg_word[SET_LO +: 2];
  wire [1:0]       c_rdh    = cfg_word[RDH_LO +: 2];
  wire [1:0]       c_wrh    = cfg_word[WRH_LO +: 2];
  wire [2:0]       hold_in  = req_write ? ({1'b0, c_wrh} + 3'd1)
                                        : ({1'b0, c_rdh} + {2'b0, cfg_word[AA_B]});
  wire [BEAT_W-1:0] beats_in = (!req_burst || req_beats == '0) ? BEAT_W'(1) : req_beats;
  wire             beat_end = (state == S_BEAT) && (cnt == '0);
  wire             last     = beats_left == BEAT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      beats_left <= '0;
      pri_q      <= '0;
      sec_q      <= '0;
      sec_en_q   <= 1'b0;
      ext_q      <= 1'b0;
      wr_q       <= 1'b0;
      hold_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state      <= S_SETUP;
          cnt        <= WS_W'(c_set);
          beats_left <= beats_in;
          pri_q      <= c_pri;
          sec_q      <= c_sec;
          sec_en_q   <= cfg_word[SEN_B];
          ext_q      <= cfg_word[EXT_B];
          wr_q       <= req_write;
          hold_q     <= hold_in;
        end
        S_SETUP: begin
          if (cnt == '0) begin
            state <= S_BEAT;
            cnt   <= pri_q;
          end else cnt <= cnt - 1'b1;
        end
        S_BEAT: begin
          if (beat_end) begin
            if (last) begin
              if (hold_q == '0) state <= S_IDLE;
              else begin
                state <= S_HOLD;
                cnt   <= WS_W'(hold_q - 3'd1);
              end
            end else begin
              beats_left <= beats_left - 1'b1;
              cnt        <= sec_en_q ? sec_q : pri_q;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                strb_q <= 1'b0;
    else if (accept)                           strb_q <= 1'b1;
    else if (strb_q && (!ext_q || state == S_BEAT)) strb_q <= 1'b0;
  end

  assign ready       = state == S_IDLE;
  assign xfer_strobe = strb_q;
  assign cs_n        = state != S_BEAT;
  assign addr_valid  = state != S_IDLE;
  assign data_drive  = wr_q && (state == S_BEAT || state == S_HOLD);
  assign xfer_ack    = beat_end;
endmodule

module bus_cycle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic ready,
  input logic xfer_strobe,
  input logic cs_n,
  input logic addr_valid,
  input logic data_drive,
  input logic xfer_ack
);
  AST_ACK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n) xfer_ack |-> !cs_n); // R5
  AST_CS_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> addr_valid); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n && !addr_valid && !xfer_ack && !xfer_strobe && !data_drive)); // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (xfer_strobe && addr_valid && cs_n && !ready)); // R4
  AST_CS_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(xfer_ack)); // R7
  AST_DATA_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n) data_drive |-> addr_valid); // R9
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
  .xfer_strobe(xfer_strobe), .cs_n(cs_n), .addr_valid(addr_valid),
  .data_drive(data_drive), .xfer_ack(xfer_ack)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BEAT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic [31:0] cfg_word = '0;
  logic ready, xfer_strobe, cs_n, addr_valid, data_drive, xfer_ack;

  int vectors = 0, fails = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_beats(req_beats), .cfg_word(cfg_word),
    .ready(ready), .xfer_strobe(xfer_strobe), .cs_n(cs_n),
    .addr_valid(addr_valid), .data_drive(data_drive), .xfer_ack(xfer_ack));

  // vector: {ready, strobe, cs_n, addr_valid, data_drive, ack}
  localparam logic [5:0] IDLE_V = 6'b101000;

  task automatic check(input logic [5:0] exp, input string tg);
    logic [5:0] act;
    string t;
    act = {ready, xfer_strobe, cs_n, addr_valid, data_drive, xfer_ack};
    vectors++;
    if (act !== exp) begin
      fails++;
      t = (act[4] !== exp[4] && tg != "R1") ? "R4" : tg;
      $display("FAIL %s: {rdy,strb,cs_n,av,dd,ack} actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic run(input logic [31:0] cfg, input logic wr, input logic burst,
                     input int beats, input string tg_over);
    int pri, sec, sen, ext, setc, rdh, wrh, aa, nb, hold;
    pri = int'(cfg[5:0]);   sec = int'(cfg[11:6]); sen = int'(cfg[12]);
    ext = int'(cfg[13]);    setc = int'(cfg[15:14]);
    rdh = int'(cfg[17:16]); wrh = int'(cfg[19:18]); aa = int'(cfg[20]);
    nb  = (!burst || beats == 0) ? 1 : beats;
    hold = wr ? wrh + 1 : rdh + aa;
    @(negedge clk);
    check(IDLE_V, "R2");
    cfg_word = cfg; req_write = wr; req_burst = burst; req_beats = BEAT_W'(beats);
    req_valid = 1'b1;
    @(posedge clk);
    for (int i = 0; i <= setc; i++) begin
      exp_q.push_back({1'b0, (i == 0) || (ext == 1), 1'b1, 1'b1, 1'b0, 1'b0});
      tag_q.push_back(tg_over != "" ? tg_over : "R3");
    end
    for (int b = 0; b < nb; b++) begin
      int w;
      w = (b == 0 || sen == 0) ? pri : sec;
      for (int j = 0; j <= w; j++) begin
        exp_q.push_back({1'b0, (ext == 1) && b == 0 && j == 0, 1'b0, 1'b1, wr, j == w});
        tag_q.push_back(tg_over != "" ? tg_over : (b == 0 ? "R5" : (sen == 1 ? "R6" : "R7")));
      end
    end
    for (int h = 0; h < hold; h++) begin
      exp_q.push_back({1'b0, 1'b0, 1'b1, 1'b1, wr, 1'b0});
      tag_q.push_back(tg_over != "" ? tg_over : (wr ? "R9" : "R8"));
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      req_valid = 1'b0;
      check(exp_q.pop_front(), tag_q.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(IDLE_V, "R2");               // reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(IDLE_V, "R2");
    // R5 defaults: single read, no waits, no hold (R8 aa=0 code 0)
    run(32'h0, 1'b0, 1'b0, 0, "");
    // R9 default write hold of one cycle
    run(32'h0, 1'b1, 1'b0, 0, "");
    // R3 R4 setup 3 with extended strobe, primary wait 2
    run(32'h0000_E002, 1'b0, 1'b0, 0, "");
    // R3 setup 1, strobe not extended
    run(32'h0000_4001, 1'b1, 1'b0, 0, "");
    // R6 burst of 4, secondary enabled: pri 3, sec 1
    run(32'h0000_1043, 1'b0, 1'b1, 4, "");
    // R7 burst of 3, secondary disabled: pri 2 (sec 5 ignored)
    run(32'h0000_0142, 1'b1, 1'b1, 3, "");
    // R7 burst with zero count is one beat
    run(32'h0000_0001, 1'b0, 1'b1, 0, "");
    // R7 single transfer ignores beat count
    run(32'h0000_0000, 1'b0, 1'b0, 7, "");
    // R8 read hold code 3, auto-ack 1 -> 4 cycles
    run(32'h0013_0000, 1'b0, 1'b0, 0, "");
    // R8 read hold code 2, auto-ack 0 -> 2 cycles
    run(32'h0002_0000, 1'b0, 1'b1, 2, "");
    // R9 write hold code 3 -> 4 cycles, burst zero-wait beats
    run(32'h000C_1000, 1'b1, 1'b1, 5, "");
    // R6 R4 extended strobe with zero setup and secondary zero waits
    run(32'h0000_3004, 1'b1, 1'b1, 3, "");
    // R1 reserved bits set: same timing as the clean word
    run(32'hFFE0_0000 | 32'h0005_6002, 1'b0, 1'b1, 2, "R1");
    run(32'h0005_6002, 1'b0, 1'b1, 2, "R1");
    // R5 long primary wait
    run(32'h0000_003F, 1'b0, 1'b1, 2, "");
    @(negedge clk);
    check(IDLE_V, "R2");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule